// File: doc/BRIEF.md
# Dual-Bank Programmable Status Calendar Sequencer

This block produces the port sequence that a packet-interface status channel walks through, one slot per enable pulse. The sequence comes from one of two slot-to-port tables. Each table holds up to `MAX_SLOTS` entries and has its own programmed length. Software grants a port more bandwidth by placing it in more than one slot. With two tables, a new allocation can be written into the idle table while the other one keeps running. Software then moves the sequencer over with a single select bit. The switch happens only at a round boundary, so no round ever mixes entries from the two tables.

Software reaches the block through a small register port with a write strobe, a read strobe and a 3-bit word address. The table contents are not defined after reset. Software must therefore load them indirectly, with the status channel held disabled. It first writes a slot address, then writes a port number into the data register of the wanted table. Read data appears one cycle after the read strobe. The sequencer outputs the port number of the current slot together with a start-of-round flag. Status encoding, parity, framing and the data path belong to other blocks.

Top module: `stat_cal_seq`

## Requirements
- R1: After reset the channel is disabled, the select bit and the error bit are 0, both length fields read 1, `slot_port` is 0 and `round_start` is 0.
- R2: Register word 1 holds the slot address. A write to word 2 stores the port in that slot of table 0, and a write to word 3 stores it in table 1. The whole 32-bit data value is the port and must be below `NPORTS`. Reading word 2 or 3 returns the stored port of the addressed slot, and every read returns its data in the cycle after `rd_en`.
- R3: While the channel is enabled, each cycle with `step` high presents the next slot's port in the following cycle. In a cycle without `step`, `slot_port` holds and `round_start` is 0.
- R4: Register word 4 holds the table 0 length in bits [8:0] and the table 1 length in bits [24:16]. A length L gives rounds of slots 0 to L-1. L = 0 acts as 1, and an L above `MAX_SLOTS` acts as `MAX_SLOTS`.
- R5: `round_start` is 1 exactly in the cycles when the port of slot 0 is presented.
- R6: Control word 0 bit1 selects table 1. A change of this bit takes effect only after the last slot of the round in progress.
- R7: A data write with a value at or above `NPORTS` leaves the table unchanged and sets an error flag, which reads as word 0 bit2. A read of word 0 returns the flag and clears it. Word 0 bit3 reads the table in use.
- R8: While word 0 bit0 is 1 the channel is disabled. `slot_port` holds, `round_start` stays 0 and the slot index returns to 0. The first round after re-enabling starts at slot 0 of the selected table.
- R9: Table 0 loaded with length 5 and ports 0,3,2,3,1 repeats exactly that sequence. Table 1 loaded with length 3 and ports 1,2,3 repeats 1,2,3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Advance one calendar slot |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, valid the cycle after `rd_en` |
| slot_port | output | PORT_W | Port number of the current slot |
| round_start | output | 1 | High while slot 0 of a round is presented |

## Verification
The sequencer is driven with a continuous `step` to reproduce the two example sequences and their round markers exactly. It is also driven with gapped and pseudo-random `step` patterns, which separate a hold from an advance. The select bit is changed mid-round, which shows whether the table switch waits for the boundary. A disable in mid-round followed by re-enable shows that the index restarts at slot 0. Lengths of 0, in range and above the maximum separate the wrap rule from the clamp. Out-of-range port writes followed by readback and by a double read of the control word show that the table is left untouched and that the error flag is sticky and cleared on read.

// File: rtl/stat_cal_pkg.sv
package stat_cal_pkg;

  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_SLOT = 3'd1,
    RA_DAT0 = 3'd2,
    RA_DAT1 = 3'd3,
    RA_LEN  = 3'd4
  } reg_addr_e;

  // A port value is legal when it lies below the configured port count.
  function automatic logic port_legal(input logic [31:0] val, input int unsigned nports);
    return val < nports;
  endfunction

  // Programmed length mapped to the number of slots actually used.
  function automatic logic [31:0] used_len(input logic [31:0] raw, input int unsigned max_slots);
    logic [31:0] r;
    r = (raw == 32'd0) ? 32'd1 : raw;
    if (r > max_slots) r = max_slots;
    return r;
  endfunction

  // True when the slot index is the final slot of a round of the given length.
  function automatic logic final_slot(input logic [31:0] idx, input logic [31:0] len);
    return (idx + 32'd1) >= len;
  endfunction

endpackage

// File: rtl/stat_cal_bank.sv
module stat_cal_bank #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int DW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wval,
  input  logic [AW-1:0] ra_seq,
  input  logic [AW-1:0] ra_reg,
  output logic [DW-1:0] rv_seq,
  output logic [DW-1:0] rv_reg
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wval;
  end

  assign rv_seq = mem[ra_seq];
  assign rv_reg = mem[ra_reg];
endmodule

// File: rtl/stat_cal_regs.sv
module stat_cal_regs
  import stat_cal_pkg::*;
#(
  parameter int NPORTS  = 16,
  parameter int PORT_W  = 4,
  parameter int SLOT_AW = 8,
  parameter int LEN_W   = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [2:0]         addr,
  input  logic [31:0]        wdata,
  input  logic [PORT_W-1:0]  tbl0_rv,
  input  logic [PORT_W-1:0]  tbl1_rv,
  input  logic               act_bank,
  output logic               chan_off,
  output logic               sel_bank,
  output logic [SLOT_AW-1:0] slot_addr,
  output logic [LEN_W-1:0]   len0,
  output logic [LEN_W-1:0]   len1,
  output logic [1:0]         bank_we,
  output logic [PORT_W-1:0]  bank_wval,
  output logic               err_set,
  output logic               err_q,
  output logic               rd_ctrl,
  output logic [31:0]        rdata
);
  logic        data_wr;
  logic        val_ok;
  logic [31:0] rd_mux;

  assign val_ok    = port_legal(wdata, NPORTS);
  assign data_wr   = wr_en && (addr == RA_DAT0 || addr == RA_DAT1);
  assign bank_we   = {wr_en && addr == RA_DAT1 && val_ok, wr_en && addr == RA_DAT0 && val_ok};
  assign bank_wval = wdata[PORT_W-1:0];
  assign err_set   = data_wr && !val_ok;
  assign rd_ctrl   = rd_en && addr == RA_CTRL;

  always_comb begin
    rd_mux = '0;
    case (addr)
      RA_CTRL: rd_mux[3:0] = {act_bank, err_q, sel_bank, chan_off};
      RA_SLOT: rd_mux[SLOT_AW-1:0] = slot_addr;
      RA_DAT0: rd_mux[PORT_W-1:0] = tbl0_rv;
      RA_DAT1: rd_mux[PORT_W-1:0] = tbl1_rv;
      RA_LEN: begin
        rd_mux[LEN_W-1:0]  = len0;
        rd_mux[16 +: LEN_W] = len1;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_off  <= 1'b1;
      sel_bank  <= 1'b0;
      slot_addr <= '0;
      len0      <= LEN_W'(1);
      len1      <= LEN_W'(1);
      err_q     <= 1'b0;
      rdata     <= '0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      if (rd_ctrl) err_q <= 1'b0;
      if (err_set) err_q <= 1'b1;
      if (wr_en) begin
        case (addr)
          RA_CTRL: begin
            chan_off <= wdata[0];
            sel_bank <= wdata[1];
          end
          RA_SLOT: slot_addr <= wdata[SLOT_AW-1:0];
          RA_LEN: begin
            len0 <= wdata[LEN_W-1:0];
            len1 <= wdata[16 +: LEN_W];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/stat_cal_stepper.sv
module stat_cal_stepper
  import stat_cal_pkg::*;
#(
  parameter int MAX_SLOTS = 256,
  parameter int PORT_W    = 4,
  parameter int SLOT_AW   = 8,
  parameter int LEN_W     = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               chan_off,
  input  logic               sel_bank,
  input  logic               step,
  input  logic [LEN_W-1:0]   len0,
  input  logic [LEN_W-1:0]   len1,
  input  logic [PORT_W-1:0]  port0,
  input  logic [PORT_W-1:0]  port1,
  output logic [SLOT_AW-1:0] slot_idx,
  output logic               act_bank,
  output logic               wrap_evt,
  output logic [PORT_W-1:0]  slot_port,
  output logic               round_start
);
  logic [31:0] cur_len;
  logic        at_end;

  assign cur_len  = used_len(32'(act_bank ? len1 : len0), MAX_SLOTS);
  assign at_end   = final_slot(32'(slot_idx), cur_len);
  assign wrap_evt = !chan_off && step && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_idx    <= '0;
      act_bank    <= 1'b0;
      slot_port   <= '0;
      round_start <= 1'b0;
    end else begin
      round_start <= 1'b0;
      if (chan_off) begin
        slot_idx <= '0;
        act_bank <= sel_bank;
      end else if (step) begin
        slot_port   <= act_bank ? port1 : port0;
        round_start <= (slot_idx == '0);
        if (at_end) begin
          slot_idx <= '0;
          act_bank <= sel_bank;
        end else begin
          slot_idx <= slot_idx + SLOT_AW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/stat_cal_seq.sv
module stat_cal_seq #(
  parameter int NPORTS    = 16,
  parameter int MAX_SLOTS = 256,
  localparam int PORT_W   = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int SLOT_AW  = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
  localparam int LEN_W    = $clog2(MAX_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [PORT_W-1:0] slot_port,
  output logic              round_start
);
  logic               chan_off, sel_bank, act_bank, wrap_evt;
  logic               err_set, err_q, rd_ctrl;
  logic [SLOT_AW-1:0] slot_addr, slot_idx;
  logic [LEN_W-1:0]   len0, len1;
  logic [1:0]         bank_we;
  logic [PORT_W-1:0]  bank_wval;
  logic [PORT_W-1:0]  rv_seq [2];
  logic [PORT_W-1:0]  rv_reg [2];

  stat_cal_regs #(.NPORTS(NPORTS), .PORT_W(PORT_W), .SLOT_AW(SLOT_AW), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .tbl0_rv(rv_reg[0]), .tbl1_rv(rv_reg[1]), .act_bank(act_bank),
    .chan_off(chan_off), .sel_bank(sel_bank), .slot_addr(slot_addr),
    .len0(len0), .len1(len1), .bank_we(bank_we), .bank_wval(bank_wval),
    .err_set(err_set), .err_q(err_q), .rd_ctrl(rd_ctrl), .rdata(rdata)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    stat_cal_bank #(.DEPTH(MAX_SLOTS), .AW(SLOT_AW), .DW(PORT_W)) u_bank (
      .clk(clk), .we(bank_we[b]), .waddr(slot_addr), .wval(bank_wval),
      .ra_seq(slot_idx), .ra_reg(slot_addr), .rv_seq(rv_seq[b]), .rv_reg(rv_reg[b])
    );
  end

  stat_cal_stepper #(.MAX_SLOTS(MAX_SLOTS), .PORT_W(PORT_W), .SLOT_AW(SLOT_AW), .LEN_W(LEN_W)) u_step (
    .clk(clk), .rst(rst), .chan_off(chan_off), .sel_bank(sel_bank), .step(step),
    .len0(len0), .len1(len1), .port0(rv_seq[0]), .port1(rv_seq[1]),
    .slot_idx(slot_idx), .act_bank(act_bank), .wrap_evt(wrap_evt),
    .slot_port(slot_port), .round_start(round_start)
  );
endmodule

// File: rtl/stat_cal_chk.sv
module stat_cal_chk #(
  parameter int NPORTS  = 16,
  parameter int PORT_W  = 4,
  parameter int SLOT_AW = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               step,
  input logic               chan_off,
  input logic               act_bank,
  input logic               wrap_evt,
  input logic [SLOT_AW-1:0] slot_idx,
  input logic [PORT_W-1:0]  slot_port,
  input logic               round_start,
  input logic               err_set,
  input logic               err_q,
  input logic               rd_ctrl
);
  p_hold_when_off_r8: assert property (@(posedge clk) disable iff (rst)
    chan_off |=> ($stable(slot_port) && !round_start));

  p_idx_home_r8: assert property (@(posedge clk) disable iff (rst)
    chan_off |=> (slot_idx == '0));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(slot_port) && !round_start));

  p_start_marks_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (!chan_off && step && slot_idx == '0) |=> round_start);

  p_bank_steady_r6: assert property (@(posedge clk) disable iff (rst)
    (!chan_off && !wrap_evt) |=> (act_bank == $past(act_bank)));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    err_set |=> err_q);

  p_err_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_ctrl && !err_set) |=> !err_q);

  p_port_legal_r2: assert property (@(posedge clk) disable iff (rst)
    round_start |-> (int'(slot_port) < NPORTS));
endmodule

bind stat_cal_seq stat_cal_chk #(.NPORTS(NPORTS), .PORT_W(PORT_W), .SLOT_AW(SLOT_AW)) u_chk (
  .clk(clk), .rst(rst), .step(step), .chan_off(chan_off), .act_bank(act_bank),
  .wrap_evt(wrap_evt), .slot_idx(slot_idx), .slot_port(slot_port),
  .round_start(round_start), .err_set(err_set), .err_q(err_q), .rd_ctrl(rd_ctrl)
);

// File: tb/stat_cal_seq_bench.sv
`timescale 1ns/1ps
module stat_cal_seq_bench;
  localparam int NP  = 16;
  localparam int MS  = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  slot_port;
  logic        round_start;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stat_cal_seq #(.NPORTS(NP), .MAX_SLOTS(MS)) u_stat_cal_seq (
    .clk(clk), .rst(rst), .step(step), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .slot_port(slot_port), .round_start(round_start)
  );

  // ---------------- behavioural reference model ----------------
  int tab0 [MS];
  int tab1 [MS];
  int m_off, m_sel, m_act, m_idx, m_port, m_rs, m_err, m_addr, m_l0, m_l1;
  longint m_rdata;

  function automatic int rounds_of(int raw);
    if (raw < 1) return 1;
    if (raw > MS) return MS;
    return raw;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_off = 1; m_sel = 0; m_act = 0; m_idx = 0; m_port = 0; m_rs = 0;
      m_err = 0; m_addr = 0; m_l0 = 1; m_l1 = 1; m_rdata = 0;
    end else begin
      int n_len;
      m_rs = 0;
      if (m_off != 0) begin
        m_idx = 0; m_act = m_sel;
      end else if (step) begin
        m_port = (m_act != 0) ? tab1[m_idx] : tab0[m_idx];
        m_rs = (m_idx == 0);
        n_len = rounds_of((m_act != 0) ? m_l1 : m_l0);
        if (m_idx >= n_len - 1) begin m_idx = 0; m_act = m_sel; end
        else m_idx++;
      end
      if (rd_en) begin
        case (addr)
          3'd0: begin m_rdata = m_off + 2*m_sel + 4*m_err + 8*m_act; m_err = 0; end
          3'd1: m_rdata = m_addr;
          3'd2: m_rdata = tab0[m_addr];
          3'd3: m_rdata = tab1[m_addr];
          3'd4: m_rdata = m_l0 + 65536*m_l1;
          default: m_rdata = 0;
        endcase
      end
      if (wr_en) begin
        case (addr)
          3'd0: begin m_off = wdata[0]; m_sel = wdata[1]; end
          3'd1: m_addr = wdata % MS;
          3'd2, 3'd3: begin
            if (longint'(wdata) < NP) begin
              if (addr == 3'd2) tab0[m_addr] = int'(wdata); else tab1[m_addr] = int'(wdata);
            end else m_err = 1;
          end
          3'd4: begin m_l0 = wdata % 512; m_l1 = (wdata >> 16) % 512; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3 slot_port vs model", slot_port, m_port);
      chk("R5 round_start vs model", round_start, m_rs);
      chk("R2 rdata vs model", rdata, m_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input longint d);
    wr_en = 1; addr = 3'(a); wdata = 32'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output longint v);
    rd_en = 1; addr = 3'(a);
    @(negedge clk);
    rd_en = 0;
    v = rdata;
  endtask

  int cap_p [600];
  int cap_r [600];

  task automatic run_steps(input int n);
    step = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cap_p[i] = slot_port; cap_r[i] = round_start;
    end
    step = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    longint v;
    int e0 [5] = '{0, 3, 2, 3, 1};
    int e1 [6] = '{2, 3, 1, 1, 2, 3};
    int cnt;
    logic [15:0] lf = 16'hACE1;

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 slot_port after reset", slot_port, 0);
    chk("R1 round_start after reset", round_start, 0);
    rd(0, v); chk("R1 control word after reset", v, 1);
    rd(4, v); chk("R1 length word after reset", v, 1 + 65536);

    // load both tables completely, then the example sequences
    for (int i = 0; i < MS; i++) begin
      wr(1, i); wr(2, i % NP); wr(3, (i * 3 + 1) % NP);
    end
    for (int i = 0; i < 5; i++) begin wr(1, i); wr(2, e0[i]); end
    for (int i = 0; i < 3; i++) begin wr(1, i); wr(3, i + 1); end
    wr(4, 5 + 65536 * 3);
    wr(1, 3); rd(2, v); chk("R2 readback of table 0 slot 3", v, 3);
    wr(1, 2); rd(3, v); chk("R2 readback of table 1 slot 2", v, 3);

    // R9 table 0 sequence, R5 markers
    wr(0, 0);
    run_steps(10);
    for (int i = 0; i < 10; i++) begin
      chk("R9 table 0 sequence", cap_p[i], e0[i % 5]);
      chk("R5 round marker", cap_r[i], (i % 5) == 0);
    end

    // R6 select change mid-round waits for the boundary
    run_steps(2);
    wr(0, 2);
    run_steps(6);
    for (int i = 0; i < 6; i++) chk("R6 switch at round end / R9 table 1", cap_p[i], e1[i]);
    chk("R6 first table 1 slot marked", cap_r[3], 1);
    rd(0, v); chk("R7 bit3 shows table 1 in use", (v >> 3) & 1, 1);

    // R3 idle cycles hold
    repeat (4) begin
      @(negedge clk);
      chk("R3 hold without step", slot_port, 3);
      chk("R3 no marker without step", round_start, 0);
    end

    // R7 out-of-range writes ignored, sticky error cleared by read
    wr(1, 7); wr(2, NP);
    rd(2, v); chk("R7 table 0 slot 7 unchanged", v, 7);
    wr(3, 40);
    rd(3, v); chk("R7 table 1 slot 7 unchanged", v, 6);
    rd(0, v); chk("R7 error flag set", (v >> 2) & 1, 1);
    rd(0, v); chk("R7 error flag cleared by read", (v >> 2) & 1, 0);

    // R8 disable mid-round, restart at slot 0 of selected table
    run_steps(1);
    chk("R8 table 1 slot 0 before disable", cap_p[0], 1);
    wr(0, 1);
    run_steps(3);
    for (int i = 0; i < 3; i++) begin
      chk("R8 port held while disabled", cap_p[i], 1);
      chk("R8 no marker while disabled", cap_r[i], 0);
    end
    wr(0, 0);
    run_steps(5);
    for (int i = 0; i < 5; i++) chk("R8 restart at slot 0 of table 0", cap_p[i], e0[i]);
    chk("R8 restart marked", cap_r[0], 1);

    // R4 length 0 acts as one slot
    wr(4, 0 + 65536 * 3);
    run_steps(4);
    for (int i = 0; i < 4; i++) begin
      chk("R4 zero length gives one slot", cap_p[i], 0);
      chk("R4 every step starts a round", cap_r[i], 1);
    end

    // R4 length above maximum clamps to MAX_SLOTS
    wr(4, 511 + 65536 * 3);
    run_steps(512);
    cnt = 0;
    for (int i = 0; i < 512; i++) cnt += cap_r[i];
    chk("R4 clamped length gives two rounds in 512 steps", cnt, 2);
    chk("R4 second round at step 256", cap_r[256], 1);

    // mixed pseudo-random stepping with reconfiguration, model compares each cycle
    for (int k = 0; k < 3000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step = lf[0];
      if (k % 97 == 5) begin
        step = 0; wr(4, 1 + (lf[3:1]) + 65536 * (1 + lf[6:4]));
      end else if (k % 131 == 7) begin
        step = 0; wr(0, {lf[9] & lf[8], 1'b0} | ((k % 393 == 7) ? 1 : 0));
      end else if (k % 173 == 11) begin
        step = 0; wr(0, {lf[2], 1'b0});
      end else begin
        @(negedge clk);
      end
    end
    step = 0;
    @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule